// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a single timer channel behind a flat 32-bit register bus: a 5-bit byte address, a write strobe, write data and a combinational read-data return. Software programs a start value, picks a counting width of 16 or 32 bits, a clock divider of 1, 16 or 256 and one of three expiry behaviours. The counter then steps down by one on every divided tick.

Expiry happens on the tick that finds the count already at zero. On expiry the block sets a sticky raw flag and then reloads, wraps or stops, depending on the mode. The interrupt line is the raw flag gated by an enable bit. Software clears the flag by writing anything to the clear word. A second reload register lets software change the next period while the current one runs on undisturbed.

When both mode bits are set, one-shot behaviour takes precedence over periodic.

Top module: `dtmr_top`

## Requirements
- R1: After reset the control word reads 0x00000020, the load word reads 0xFFFFFFFF, the current-count word reads 0x0000FFFF (the internal count is all ones and the reset width is 16 bits), and the raw flag, the masked flag and `irq_o` are all 0.
- R2: Word addresses are byte offsets. 0x00 is load and 0x04 is current count. 0x08 is control. 0x0C is interrupt clear (reads 0). 0x10 is the raw flag and 0x14 the masked flag, both in bit 0. 0x18 is background load and 0x1C is reserved. The reserved word reads 0 and ignores writes. Control bits other than 7, 6, 5, 3, 2, 1 and 0 read 0.
- R3: Control bit 7 enables counting. While enabled, each tick lowers the count by one. A write to the load word sets the current count at once, masked to the selected width, and this takes precedence over a tick in the same cycle.
- R4: With control bit 6 set (periodic) and bit 0 clear, a tick at count zero sets the raw flag and reloads the count from the reload value.
- R5: A write to the background load word changes only the reload value. The current count is unchanged, and the new value is used at the next expiry. Both 0x00 and 0x18 read back the reload value.
- R6: With control bits 6 and 0 both clear (free-running), expiry sets the raw flag and wraps the count to the width maximum (0xFFFF or 0xFFFFFFFF).
- R7: With control bit 0 set (one-shot), expiry sets the raw flag once. The count then holds at zero and raises no further flags until the load word or the control word is written.
- R8: With control bit 1 clear, only the low 16 bits count and are tested for zero, and the current-count word reads 0 in bits 31:16. With bit 1 set, all 32 bits count.
- R9: Control bits 3:2 select the tick divider: 00 gives one tick per clock, 01 one per 16 clocks and 10 or 11 one per 256 clocks. The first tick comes the full divider period after enabling. The divider restarts from zero whenever the timer is disabled.
- R10: Any write to the interrupt clear word clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R11: `irq_o` and the masked status bit equal the raw flag ANDed with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 5 | Byte address of the register word |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Masked interrupt |

## Verification
A register write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle. The bench therefore drives on the falling edge and samples one falling edge after each write. With the divider at 1, the count drops by one at each edge after the enabling write. Expiry from a start value L shows at edge L+1, so the flags are checked one cycle before and at that edge. With the divider at 16 or 256, the first change lands exactly 16 or 256 edges after enabling. Each scenario counts edges from its own enabling write and checks both the cycle before a change and the cycle of the change.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int HALF_W = DATA_W / 2;
    localparam int PRE_W  = 8;

    // control bit positions (software decodes these)
    localparam int CB_EN       = 7;
    localparam int CB_PERIODIC = 6;
    localparam int CB_IE       = 5;
    localparam int CB_PRE_HI   = 3;
    localparam int CB_PRE_LO   = 2;
    localparam int CB_WIDE     = 1;
    localparam int CB_ONESHOT  = 0;

    typedef enum logic [2:0] {
        RSEL_LOAD    = 3'd0,
        RSEL_COUNT   = 3'd1,
        RSEL_CTRL    = 3'd2,
        RSEL_ICLR    = 3'd3,
        RSEL_RAW     = 3'd4,
        RSEL_MASKED  = 3'd5,
        RSEL_BGLOAD  = 3'd6,
        RSEL_RSVD    = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } run_mode_e;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       ie;
        logic [1:0] pre;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{en: 1'b0, periodic: 1'b0, ie: 1'b1,
                                     pre: 2'b00, wide: 1'b0, oneshot: 1'b0};

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en       = w[CB_EN];
        c.periodic = w[CB_PERIODIC];
        c.ie       = w[CB_IE];
        c.pre      = w[CB_PRE_HI:CB_PRE_LO];
        c.wide     = w[CB_WIDE];
        c.oneshot  = w[CB_ONESHOT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CB_EN]              = c.en;
        w[CB_PERIODIC]        = c.periodic;
        w[CB_IE]              = c.ie;
        w[CB_PRE_HI:CB_PRE_LO] = c.pre;
        w[CB_WIDE]            = c.wide;
        w[CB_ONESHOT]         = c.oneshot;
        return w;
    endfunction

    function automatic run_mode_e mode_of(input ctrl_t c);
        if (c.oneshot)       return MODE_ONESHOT;
        else if (c.periodic) return MODE_PERIODIC;
        else                 return MODE_FREE;
    endfunction

    // terminal value of the divider counter for each code
    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
        case (code)
            2'b00:   return '0;
            2'b01:   return PRE_W'(15);
            default: return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
    import dtmr_pkg::*;
#(
    parameter int CNT_W = PRE_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] div_q;
    logic             at_limit;

    assign at_limit = (div_q == limit_i);
    assign tick_o   = run_i && at_limit;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            div_q <= '0;
        end else if (at_limit) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
    import dtmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] count_i,
    input  logic          raw_i,
    output logic [DW-1:0] rdata_o,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] reload_o,
    output logic          load_wr_o,
    output logic          ctrl_wr_o,
    output logic          clr_wr_o
);

    localparam int SEL_LO = 2;
    localparam int SEL_HI = SEL_LO + 2;

    reg_sel_e      sel;
    logic          bg_wr;
    ctrl_t         ctrl_q;
    logic [DW-1:0] reload_q;
    logic [DW-1:0] count_vis;

    assign sel       = reg_sel_e'(addr_i[SEL_HI:SEL_LO]);
    assign load_wr_o = we_i && (sel == RSEL_LOAD);
    assign ctrl_wr_o = we_i && (sel == RSEL_CTRL);
    assign clr_wr_o  = we_i && (sel == RSEL_ICLR);
    assign bg_wr     = we_i && (sel == RSEL_BGLOAD);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q   <= CTRL_RESET;
            reload_q <= '1;
        end else begin
            if (ctrl_wr_o) begin
                ctrl_q <= ctrl_from_word(wdata_i);
            end
            if (load_wr_o || bg_wr) begin
                reload_q <= wdata_i;
            end
        end
    end

    assign count_vis = count_i & width_mask(ctrl_q.wide);

    always_comb begin
        rdata_o = '0;
        case (sel)
            RSEL_LOAD,
            RSEL_BGLOAD: rdata_o = reload_q;
            RSEL_COUNT:  rdata_o = count_vis;
            RSEL_CTRL:   rdata_o = ctrl_to_word(ctrl_q);
            RSEL_RAW:    rdata_o[0] = raw_i;
            RSEL_MASKED: rdata_o[0] = raw_i & ctrl_q.ie;
            default:     rdata_o = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  run_mode_e     mode_i,
    input  logic          wide_i,
    input  logic          load_wr_i,
    input  logic [DW-1:0] load_data_i,
    input  logic [DW-1:0] reload_i,
    input  logic          ctrl_wr_i,
    input  logic          clr_i,
    output logic [DW-1:0] count_o,
    output logic          raw_o,
    output logic          expire_o,
    output logic          stopped_o
);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] lim_mask;
    logic [DW-1:0] eff;
    logic [DW-1:0] cnt_d;
    logic          stop_q;
    logic          stop_d;
    logic          raw_q;
    logic          at_zero;

    assign lim_mask = width_mask(wide_i);
    assign eff      = cnt_q & lim_mask;
    assign at_zero  = (eff == '0);
    assign expire_o = tick_i && at_zero && !stop_q;

    always_comb begin
        cnt_d  = cnt_q;
        stop_d = stop_q;
        if (load_wr_i) begin
            cnt_d  = load_data_i & lim_mask;
            stop_d = 1'b0;
        end else begin
            if (ctrl_wr_i) begin
                stop_d = 1'b0;
            end
            if (tick_i && !stop_q) begin
                if (at_zero) begin
                    case (mode_i)
                        MODE_PERIODIC: cnt_d = reload_i & lim_mask;
                        MODE_ONESHOT: begin
                            cnt_d  = '0;
                            stop_d = 1'b1;
                        end
                        default:       cnt_d = lim_mask;
                    endcase
                end else begin
                    cnt_d = eff - DW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '1;
            stop_q <= 1'b0;
            raw_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            stop_q <= stop_d;
            if (expire_o) begin
                raw_q <= 1'b1;
            end else if (clr_i) begin
                raw_q <= 1'b0;
            end
        end
    end

    assign count_o   = cnt_q;
    assign raw_o     = raw_q;
    assign stopped_o = stop_q;

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] count_val;
    logic              load_wr;
    logic              ctrl_wr;
    logic              clr_wr;
    logic              tick;
    logic              raw_q;
    logic              expire;
    logic              stopped;

    dtmr_regfile #(.DW(DATA_W), .AW(ADDR_W)) regs_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .addr_i    (bus_addr_i),
        .we_i      (bus_we_i),
        .wdata_i   (bus_wdata_i),
        .count_i   (count_val),
        .raw_i     (raw_q),
        .rdata_o   (bus_rdata_o),
        .ctrl_o    (ctrl),
        .reload_o  (reload_val),
        .load_wr_o (load_wr),
        .ctrl_wr_o (ctrl_wr),
        .clr_wr_o  (clr_wr)
    );

    dtmr_prescaler #(.CNT_W(PRE_W)) div_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (ctrl.en),
        .limit_i (pre_limit(ctrl.pre)),
        .tick_o  (tick)
    );

    dtmr_counter #(.DW(DATA_W)) cnt_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick),
        .mode_i      (mode_of(ctrl)),
        .wide_i      (ctrl.wide),
        .load_wr_i   (load_wr),
        .load_data_i (bus_wdata_i),
        .reload_i    (reload_val),
        .ctrl_wr_i   (ctrl_wr),
        .clr_i       (clr_wr),
        .count_o     (count_val),
        .raw_o       (raw_q),
        .expire_o    (expire),
        .stopped_o   (stopped)
    );

    assign irq_o = raw_q & ctrl.ie;

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              we_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic              irq_i,
    input logic              raw_i,
    input logic              expire_i,
    input logic              tick_i,
    input logic [DATA_W-1:0] count_i,
    input logic              wide_i,
    input logic              stopped_i
);

    logic [2:0] sel;
    assign sel = addr_i[4:2];

    AST_LOAD_IMMEDIATE: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && sel == 3'd0) |=> ((count_i & width_mask($past(wide_i))) == ($past(wdata_i) & width_mask($past(wide_i))))); // R3

    AST_BGLOAD_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && sel == 3'd6 && !tick_i) |=> $stable(count_i)); // R5

    AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (stopped_i && !(we_i && sel == 3'd0)) |=> $stable(count_i)); // R7

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wide_i && sel == 3'd1) |-> (rdata_i[DATA_W-1:HALF_W] == '0)); // R8

    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && sel == 3'd3 && !expire_i) |=> !raw_i); // R10

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        expire_i |=> raw_i); // R10

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_i |-> raw_i); // R11

endmodule

bind dtmr_top dtmr_checker chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .wdata_i   (bus_wdata_i),
    .rdata_i   (bus_rdata_o),
    .irq_i     (irq_o),
    .raw_i     (raw_q),
    .expire_i  (expire),
    .tick_i    (tick),
    .count_i   (count_val),
    .wide_i    (ctrl.wide),
    .stopped_i (stopped)
);

// File: tb/dtmr_top_tb_top.sv
`timescale 1ns/1ps
module dtmr_top_tb_top;

    localparam logic [4:0] A_LOAD = 5'h00;
    localparam logic [4:0] A_CNT  = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_ICLR = 5'h0C;
    localparam logic [4:0] A_RAW  = 5'h10;
    localparam logic [4:0] A_MSK  = 5'h14;
    localparam logic [4:0] A_BG   = 5'h18;
    localparam logic [4:0] A_RSVD = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dtmr_top dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input string req, input string what,
                              input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, what, v, exp);
    endtask

    task automatic park();
        wr(A_CTRL, 32'h22);
        wr(A_ICLR, 32'h0);
    endtask

    task automatic t_reset();
        expect_reg("R1", "ctrl after reset", A_CTRL, 32'h20);
        expect_reg("R1", "load after reset", A_LOAD, 32'hFFFF_FFFF);
        expect_reg("R1", "count after reset", A_CNT, 32'h0000_FFFF);
        expect_reg("R1", "raw after reset", A_RAW, 32'h0);
        expect_reg("R1", "masked after reset", A_MSK, 32'h0);
        check("R1", "irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_regmap();
        wr(A_RSVD, 32'hDEAD_BEEF);
        expect_reg("R2", "reserved reads zero", A_RSVD, 32'h0);
        expect_reg("R2", "clear word reads zero", A_ICLR, 32'h0);
        wr(A_CTRL, 32'hFFFF_FF30);
        expect_reg("R2", "unused ctrl bits", A_CTRL, 32'h20);
        expect_reg("R2", "load untouched by reserved write", A_LOAD, 32'hFFFF_FFFF);
    endtask

    task automatic t_periodic();
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'hE2);
        wait_cyc(3);
        expect_reg("R3", "count after 3 ticks", A_CNT, 32'd2);
        wait_cyc(2);
        expect_reg("R3", "count reaches zero", A_CNT, 32'd0);
        expect_reg("R4", "no flag before expiry", A_RAW, 32'h0);
        wait_cyc(1);
        expect_reg("R4", "raw at expiry", A_RAW, 32'h1);
        expect_reg("R4", "reloaded count", A_CNT, 32'd5);
        check("R11", "irq with ie set", {31'h0, irq}, 32'h1);
        expect_reg("R11", "masked with ie set", A_MSK, 32'h1);
        wr(A_ICLR, 32'h0);
        expect_reg("R10", "raw after clear", A_RAW, 32'h0);
        check("R10", "irq after clear", {31'h0, irq}, 32'h0);
        park();
    endtask

    task automatic t_load_now();
        wr(A_LOAD, 32'd20);
        wr(A_CTRL, 32'hE2);
        wait_cyc(3);
        expect_reg("R3", "count before reload", A_CNT, 32'd17);
        wr(A_LOAD, 32'd7);
        expect_reg("R3", "load write sets count at once", A_CNT, 32'd7);
        wait_cyc(1);
        expect_reg("R3", "count after next tick", A_CNT, 32'd6);
        park();
    endtask

    task automatic t_bgload();
        wr(A_LOAD, 32'd4);
        wr(A_CTRL, 32'hE2);
        wr(A_BG, 32'd9);
        expect_reg("R5", "count unchanged by bg write", A_CNT, 32'd3);
        expect_reg("R5", "reload reads new value", A_LOAD, 32'd9);
        wait_cyc(4);
        expect_reg("R5", "raw at expiry", A_RAW, 32'h1);
        expect_reg("R5", "reload uses bg value", A_CNT, 32'd9);
        park();
    endtask

    task automatic t_free16();
        wr(A_CTRL, 32'h20);
        wr(A_LOAD, 32'h1234_0002);
        expect_reg("R8", "narrow load masked", A_CNT, 32'h0000_0002);
        wr(A_CTRL, 32'hA0);
        wait_cyc(2);
        expect_reg("R6", "free count at zero", A_CNT, 32'h0);
        wait_cyc(1);
        expect_reg("R6", "wraps to 16-bit max", A_CNT, 32'h0000_FFFF);
        expect_reg("R6", "raw on wrap", A_RAW, 32'h1);
        wait_cyc(1);
        expect_reg("R8", "narrow count keeps upper zero", A_CNT, 32'h0000_FFFE);
        park();
    endtask

    task automatic t_free32();
        wr(A_CTRL, 32'h22);
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'hA2);
        wait_cyc(2);
        expect_reg("R6", "wraps to 32-bit max", A_CNT, 32'hFFFF_FFFF);
        wait_cyc(1);
        expect_reg("R8", "wide count uses all bits", A_CNT, 32'hFFFF_FFFE);
        park();
    endtask

    task automatic t_oneshot();
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'hA3);
        wait_cyc(3);
        expect_reg("R7", "no flag before expiry", A_RAW, 32'h0);
        wait_cyc(1);
        expect_reg("R7", "raw at expiry", A_RAW, 32'h1);
        expect_reg("R7", "count at zero", A_CNT, 32'h0);
        wait_cyc(5);
        expect_reg("R7", "count held at zero", A_CNT, 32'h0);
        wr(A_ICLR, 32'h0);
        wait_cyc(5);
        expect_reg("R7", "no second flag", A_RAW, 32'h0);
        park();
    endtask

    task automatic t_div16();
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'hC6);
        wait_cyc(15);
        expect_reg("R9", "div16 before first tick", A_CNT, 32'd2);
        wait_cyc(1);
        expect_reg("R9", "div16 first tick", A_CNT, 32'd1);
        wait_cyc(31);
        expect_reg("R9", "div16 no flag yet", A_RAW, 32'h0);
        wait_cyc(1);
        expect_reg("R9", "div16 expiry", A_RAW, 32'h1);
        check("R11", "irq masked off", {31'h0, irq}, 32'h0);
        expect_reg("R11", "masked status off", A_MSK, 32'h0);
        park();
    endtask

    task automatic t_div_restart();
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'hC6);
        wait_cyc(9);
        wr(A_CTRL, 32'h46);
        wr(A_CTRL, 32'hC6);
        wait_cyc(15);
        expect_reg("R9", "divider restarted", A_CNT, 32'd5);
        wait_cyc(1);
        expect_reg("R9", "first tick after restart", A_CNT, 32'd4);
        park();
    endtask

    task automatic t_div256(input logic [31:0] ctrl_word, input string tag);
        wr(A_LOAD, 32'd0);
        wr(A_CTRL, ctrl_word);
        wait_cyc(255);
        expect_reg("R9", {tag, " no tick yet"}, A_RAW, 32'h0);
        wait_cyc(1);
        expect_reg("R9", {tag, " tick at 256"}, A_RAW, 32'h1);
        park();
    endtask

    task automatic t_priority();
        wr(A_LOAD, 32'd0);
        wr(A_CTRL, 32'hE2);
        wait_cyc(2);
        wr(A_ICLR, 32'h0);
        expect_reg("R10", "set wins over clear", A_RAW, 32'h1);
        park();
        expect_reg("R10", "clear when idle", A_RAW, 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_regmap();
        t_periodic();
        t_load_now();
        t_bgload();
        t_free16();
        t_free32();
        t_oneshot();
        t_div16();
        t_div_restart();
        t_div256(32'hCA, "code10");
        t_div256(32'hCE, "code11");
        t_priority();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule